// File: doc/BRIEF.md
# Zero-turnaround flow-through synchronous SRAM

This block models a synchronous static memory with flow-through reads that can take a read or a write command on every clock, in any mix, without idle cycles between a write and a read. A command is registered on the rising edge. Read data then comes straight out of the array in the same cycle. Write data follows one cycle after its command, and the bytes are merged into the array under a per-lane mask.

A two-bit burst counter lets a host send one load command and then advance through four consecutive words. The order is either linear or interleaved. A clock enable stalls the whole pipeline. A sleep input blocks new commands. The output-enable pin gates the read drivers without waiting for a clock edge. The three chip-select inputs give simple depth expansion.

Top module: `zbt_ft_sram`

## Requirements
- R1: A read command registered on a rising edge drives `rdata` from the word at its address, with `rdata_oe` high, during the cycle that follows that edge.
- R2: At an edge where `clk_en` is low, nothing is registered: the command, the address, the pending write data and the outputs all hold.
- R3: Writes and reads may be issued on consecutive cycles. A read issued in the cycle that carries the data of a write to the same address returns the new data.
- R4: A write changes only the lanes whose `byte_sel` bit is 1. Lane i is `wdata[9*i+8 : 9*i]`, and the mask is taken with the command.
- R5: A load cycle (`adv_ld`=0) selects the device only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination is a deselect, and `rdata_oe` is low for the following cycle.
- R6: `rdata_oe` is low in the cycle after a write command, which is the write's data cycle, whatever the level of `oe_n`.
- R7: While `oe_n` is high, `rdata_oe` is low. The output follows `oe_n` without a clock edge.
- R8: With `burst_ilv`=0 at load time, each advance (`adv_ld`=1) steps the two low address bits as start+count modulo 4.
- R9: With `burst_ilv`=1 at load time, the two low address bits are start XOR count. The count wraps after four beats.
- R10: An advance keeps the read/write type of the current burst and ignores the chip selects. An advance after a deselect stays deselected.
- R11: While `sleep` is high, no command is accepted: the next cycle is a deselect and `rdata_oe` is low at once. A write already in its data cycle still completes.
- R12: During reset and right after it, the device is deselected and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | High lets an edge take effect; low stalls everything |
| wr_en | input | 1 | 1 = write, 0 = read on a load cycle |
| byte_sel | input | LANES | Per-lane write mask, active high |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down: blocks commands, forces outputs off |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken one cycle after its command |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | Read driver enable (high = drive bus) |

## Verification
Every stimulus is applied on the falling edge. Each registered result is therefore due in the half cycle after the very next rising edge, and write data lands at the edge that follows its command's edge. The scoreboard queues one expectation for each applied cycle. The monitor pops it two time units after the rising edge that consumes it, so the checks always fall in the cycle the result is due. The expectations for the asynchronous effects of `oe_n` and `sleep` are checked one time unit after the pin changes, with no clock edge in between.

// File: rtl/zft_pkg.sv
package zft_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       ilv;
    logic [1:0] cnt;
  } ctl_t;
endpackage

// File: rtl/zft_rst_sync.sv
module zft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/zft_cmd_stage.sv
module zft_cmd_stage
  import zft_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              adv_ld,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              ilv_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_sel,
  output ctl_t              ctl_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [LANES-1:0]  mask_q
);
  ctl_t              ctl_d;
  logic [ADDR_W-1:0] base_d;
  logic [LANES-1:0]  mask_d;

  always_comb begin
    ctl_d  = ctl_q;
    base_d = base_q;
    mask_d = mask_q;
    if (sleep) begin
      ctl_d.op = OP_DESEL;
    end else if (adv_ld) begin
      if (ctl_q.op != OP_DESEL) begin
        ctl_d.cnt = ctl_q.cnt + 2'd1;
        mask_d    = byte_sel;
      end
    end else begin
      ctl_d.op  = !sel ? OP_DESEL : (wr_en ? OP_WRITE : OP_READ);
      ctl_d.cnt = 2'd0;
      ctl_d.ilv = ilv_in;
      base_d    = addr;
      mask_d    = byte_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{op: OP_DESEL, ilv: 1'b0, cnt: 2'd0};
      base_q <= '0;
      mask_q <= '0;
    end else if (clk_en) begin
      ctl_q  <= ctl_d;
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/zft_burst_addr.sv
module zft_burst_addr #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        cnt,
  input  logic              ilv,
  output logic [ADDR_W-1:0] eff
);
  logic [1:0] low;

  always_comb begin
    low = ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
    eff = {base[ADDR_W-1:2], low};
  end
endmodule

// File: rtl/zft_lane_mem.sv
module zft_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       adr,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && mask[g]) begin
        cells[adr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[adr];
  end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zft_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        byte_sel,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    adv_ld,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW = LANES * LANE_W;

  logic              rst_s_n;
  logic              sel;
  ctl_t              ctl;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  mask;
  logic              mem_we;
  logic [DW-1:0]     mem_rd;

  assign sel = !ce_a_n && ce_b && !ce_c_n;

  zft_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  zft_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clk_en   (clk_en),
    .sleep    (sleep),
    .adv_ld   (adv_ld),
    .sel      (sel),
    .wr_en    (wr_en),
    .ilv_in   (burst_ilv),
    .addr     (addr),
    .byte_sel (byte_sel),
    .ctl_q    (ctl),
    .base_q   (base_addr),
    .mask_q   (mask)
  );

  zft_burst_addr #(.ADDR_W(ADDR_W)) u_bad (
    .base (base_addr),
    .cnt  (ctl.cnt),
    .ilv  (ctl.ilv),
    .eff  (eff_addr)
  );

  // write data is taken at the edge after the command edge
  assign mem_we = clk_en && (ctl.op == OP_WRITE);

  zft_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .adr   (eff_addr),
    .mask  (mask),
    .wdata (wdata),
    .rdata (mem_rd)
  );

  assign rdata    = mem_rd;
  assign rdata_oe = (ctl.op == OP_READ) && !oe_n && !sleep;
endmodule

// File: rtl/zft_chk.sv
module zft_chk
  import zft_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              clk_en,
  input logic              sleep,
  input logic              adv_ld,
  input logic              sel,
  input logic              oe_n,
  input ctl_t              ctl,
  input logic [ADDR_W-1:0] base_addr,
  input logic              rdata_oe
);
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !clk_en |=> ($stable(ctl) && $stable(base_addr)));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clk_en && !sleep && !adv_ld && !sel) |=> (ctl.op == OP_DESEL));

  p_wr_hiz_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl.op == OP_WRITE) |-> !rdata_oe);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    oe_n |-> !rdata_oe);

  p_burst_step_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clk_en && !sleep && adv_ld && ctl.op != OP_DESEL)
      |=> ((ctl.cnt == $past(ctl.cnt) + 2'd1) && (ctl.op == $past(ctl.op))));

  p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clk_en && sleep) |=> (ctl.op == OP_DESEL));

  p_sleep_hiz_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    sleep |-> !rdata_oe);
endmodule

bind zbt_ft_sram zft_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .clk_en    (clk_en),
  .sleep     (sleep),
  .adv_ld    (adv_ld),
  .sel       (sel),
  .oe_n      (oe_n),
  .ctl       (ctl),
  .base_addr (base_addr),
  .rdata_oe  (rdata_oe)
);

// File: tb/test_zbt_ft_sram.sv
module test_zbt_ft_sram;
  localparam int AW = 8;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, clk_en, wr_en, ce_a_n, ce_b, ce_c_n, adv_ld, burst_ilv, oe_n, sleep;
  logic [LANES-1:0] byte_sel;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata, rdata;
  logic             rdata_oe;

  zbt_ft_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) i_zbt_ft_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .byte_sel(byte_sel),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv_ld(adv_ld),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct {
    logic          oe;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(string tag, logic [DW:0] act, logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual oe/data=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                        logic [LANES-1:0] m);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  // monitor: one expectation per applied cycle, due after the next rising edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(e.tag, {rdata_oe, e.oe ? rdata : {DW{1'b0}}}, {e.oe, e.oe ? e.d : {DW{1'b0}}});
    end
  end

  task automatic go(logic oe, logic [DW-1:0] d, string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, logic ilv = 1'b0);
    adv_ld = 1'b0; wr_en = 1'b0; ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    addr = a; burst_ilv = ilv;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [LANES-1:0] m, logic ilv = 1'b0);
    adv_ld = 1'b0; wr_en = 1'b1; ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    addr = a; byte_sel = m; burst_ilv = ilv;
  endtask

  task automatic adv(logic [LANES-1:0] m = '1);
    adv_ld = 1'b1; byte_sel = m; ce_b = 1'b0; addr = '0;
  endtask

  localparam logic [DW-1:0] P  = 36'h123456789;
  localparam logic [DW-1:0] D1 = 36'h9ABCDEF01;
  localparam logic [DW-1:0] D2 = 36'h0FEDCBA98;
  localparam logic [DW-1:0] D3 = 36'h3C3C3C3C3;
  localparam logic [DW-1:0] D9 = 36'h555555555;
  localparam logic [DW-1:0] JK = 36'hAAAAAAAAA;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] m11;
    rst_n = 1'b0; clk_en = 1'b1; wr_en = 1'b0; ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    adv_ld = 1'b0; burst_ilv = 1'b0; oe_n = 1'b0; sleep = 1'b0; byte_sel = '1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R12 in reset", {rdata_oe, {DW{1'b0}}}, '0);
    rd(8'h00); ce_b = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after reset", {rdata_oe, {DW{1'b0}}}, '0);

    // back-to-back writes and reads
    wr(8'h11, 4'hF);               go(1'b0, '0, "R6 write data cycle");
    wdata = P;  wr(8'h10, 4'hF);   go(1'b0, '0, "R6 write after write");
    wdata = D1; rd(8'h11);         go(1'b1, P, "R3 read right after write");
    wr(8'h11, 4'b0101);            go(1'b0, '0, "R6 masked write");
    m11 = mrg(P, D2, 4'b0101);
    wdata = D2; rd(8'h11);         go(1'b1, m11, "R4 byte mask merge");
    rd(8'h10);                     go(1'b1, D1, "R1 flow-through read");
    rd(8'h10); ce_c_n = 1'b1;      go(1'b0, '0, "R5 deselect");
    adv();                         go(1'b0, '0, "R10 advance after deselect");
    rd(8'h10); oe_n = 1'b1;        go(1'b0, '0, "R7 oe_n high");
    oe_n = 1'b0; #1;
    chk("R7 async oe_n release", {rdata_oe, rdata}, {1'b1, D1});

    // clock-enable stall
    rd(8'h11);                     go(1'b1, m11, "R1 read");
    clk_en = 1'b0; rd(8'h10);      go(1'b1, m11, "R2 stall holds read");
    clk_en = 1'b1; wr(8'h30, 4'hF); go(1'b0, '0, "R6 write");
    clk_en = 1'b0; wdata = JK; rd(8'h10); go(1'b0, '0, "R2 stall in data cycle");
    clk_en = 1'b1; wdata = D3; rd(8'h30); go(1'b1, D3, "R2 data after stall");

    // linear write burst from 0x21: lands at 21,22,23,20
    wr(8'h21, 4'hF, 1'b0);         go(1'b0, '0, "R8 burst write load");
    wdata = 36'h0000000A0; adv();  go(1'b0, '0, "R10 burst keeps write");
    wdata = 36'h0000000A1; adv();  go(1'b0, '0, "R10 burst keeps write");
    wdata = 36'h0000000A2; adv();  go(1'b0, '0, "R10 burst keeps write");
    wdata = 36'h0000000A3; rd(8'h22, 1'b0); go(1'b1, 36'h0000000A1, "R8 linear beat0");
    adv();                         go(1'b1, 36'h0000000A2, "R8 linear beat1");
    adv();                         go(1'b1, 36'h0000000A3, "R8 linear wrap beat2");
    adv();                         go(1'b1, 36'h0000000A0, "R8 linear beat3");

    // interleaved read from 0x21: 21,20,23,22, then wrap to 21
    rd(8'h21, 1'b1);               go(1'b1, 36'h0000000A0, "R9 ilv beat0");
    adv();                         go(1'b1, 36'h0000000A3, "R9 ilv beat1");
    adv();                         go(1'b1, 36'h0000000A2, "R9 ilv beat2");
    adv();                         go(1'b1, 36'h0000000A1, "R9 ilv beat3");
    adv();                         go(1'b1, 36'h0000000A0, "R9 ilv count wrap");

    // sleep
    sleep = 1'b1; wr(8'h10, 4'hF); go(1'b0, '0, "R11 sleep blocks write");
    sleep = 1'b0; wdata = D9; rd(8'h10); go(1'b1, D1, "R11 blocked write left word");
    sleep = 1'b1; #1;
    chk("R11 async sleep gating", {rdata_oe, {DW{1'b0}}}, '0);
    @(negedge clk);
    sleep = 1'b0; rd(8'h10);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 scoreboard: actual=%0d left expected=0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule